// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block is a synchronous controller for a 256K x 32 asynchronous EDO DRAM. On the host side it takes one request at a time through a valid/ready handshake. A request carries an 18-bit word address, 32 bits of write data, four byte enables and a read/write flag. Read data comes back with a one-cycle valid strobe. On the memory side it drives the row strobe, four per-byte column strobes, the write and output enables, a 9-bit multiplexed address bus and a data bus with a separate drive enable.

The upper nine address bits select the row and the lower nine select the column. After an access the row stays open. A later request to the same row runs as a column-only cycle. A request to a different row first closes the open one and waits out the precharge time. Writes are always early writes: the write enable is asserted before any column strobe falls, and the output enable stays off. All DRAM timing minimums are given in nanoseconds and converted to whole clocks, rounding up. The longest allowed row-strobe low time is converted rounding down.

Refresh and power-up initialization belong to a separate sequencer. The controller gives up the memory to that sequencer through a request/grant pair, and it closes its open row before it grants.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While and after reset, with no request pending: row strobe high, all four column strobes high, write enable high, output enable high, data drive off, `rsp_valid` low, `ref_gnt` low and `req_ready` high.
- R2: When the row strobe falls, the address pins carry address bits [17:9]. When a column strobe falls, the address pins carry bits [8:0].
- R3: In a write, the write enable is low in the cycle before the column strobes fall and stays low while they are low. The output enable stays high during the write. Column strobe i (byte lane i = data bits 8i+7..8i) falls only when byte enable i is 1. A write with byte enable 0 leaves that byte of memory unchanged.
- R4: In a read, the output enable is low while the column strobes are low. The data is captured one clock after the CAS-access count has elapsed. `rsp_valid` is a single-cycle pulse. Byte lanes whose enable is 0 return zero.
- R5: A request whose row equals the open row produces no new fall of the row strobe.
- R6: A request to another row raises the row strobe for at least ceil(T_RP_NS/CLK_NS) clocks before it falls again.
- R7: At least ceil(T_RCD_NS/CLK_NS) clocks pass from a row-strobe fall to the first column-strobe fall. Within one open row, the column strobes stay high for at least ceil(T_CP_NS/CLK_NS) clocks between accesses.
- R8: The row strobe never stays low longer than floor(T_RASMAX_NS/CLK_NS) clocks. An idle open row is closed before that limit.
- R9: While `ref_req` is high, the controller closes any open row, then raises `ref_gnt` with all strobes high and `req_ready` low. It takes requests again once `ref_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: row [17:9], column [8:0] |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for data bits 8i+7..8i |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh sequencer asks for the memory |
| ref_gnt | output | 1 | Memory handed to the sequencer |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-byte column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_o | output | 32 | Data to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 32 | Data from the memory |

## Verification
The bench uses an 8 ns clock and leaves the nanosecond timing parameters at their defaults. That gives precharge and row-to-column counts of three clocks and a CAS-access count of two. Its memory model drives garbage until the access count has passed, so a capture one clock too early shows up as a wrong read. The row-low limit is lowered from 100,000 ns to 400 ns (50 clocks). A burst of page hits and an idle wait can then run into the forced row close within a short run.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_RCD, ST_COL, ST_CAS, ST_CP, ST_GNT
  } edo_st_e;

  // nanoseconds to clocks, rounded up, never below one clock
  function automatic int ns2clk(input int ns, input int clk_ns);
    int n;
    n = (ns + clk_ns - 1) / clk_ns;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // longest stretch a page access can keep the row strobe low after acceptance
  function automatic int page_guard(input int n_caslo, input int n_cp);
    return n_caslo + n_cp + 2;
  endfunction

endpackage

// File: rtl/edo_page_track.sv
module edo_page_track #(
  parameter int ROW_W    = 9,
  parameter int N_RP     = 3,
  parameter int N_RASMAX = 12500,
  parameter int GUARD    = 6,
  localparam int RCW     = $clog2(N_RASMAX + 2),
  localparam int PW      = $clog2(N_RP + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_low,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] row_in,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             row_open,
  output logic             row_hit,
  output logic             near_limit,
  output logic [RCW-1:0]   ras_cnt
);

  localparam logic [RCW-1:0] LIMIT = RCW'(N_RASMAX - GUARD);
  localparam logic [PW-1:0]  PRE_SAT = PW'(N_RP);

  logic [ROW_W-1:0] open_row;
  logic [PW-1:0]    pre_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      open_row <= '0;
    end else if (open_set) begin
      row_open <= 1'b1;
      open_row <= row_in;
    end else if (open_clr) begin
      row_open <= 1'b0;
    end
  end

  // cycles the row strobe has been low, zero while high
  always_ff @(posedge clk) begin
    if (!rst_n)                    ras_cnt <= '0;
    else if (!ras_low)             ras_cnt <= '0;
    else if (ras_cnt != '1)        ras_cnt <= ras_cnt + 1'b1;
  end

  // saturating count of high cycles; reset counts as precharged
  always_ff @(posedge clk) begin
    if (!rst_n)                    pre_cnt <= PRE_SAT;
    else if (ras_low)              pre_cnt <= '0;
    else if (pre_cnt < PRE_SAT)    pre_cnt <= pre_cnt + 1'b1;
  end

  assign row_hit    = row_open && (open_row == cmp_row);
  assign near_limit = ras_low && (ras_cnt >= LIMIT);

  p_ras_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (ras_cnt < RCW'(N_RASMAX)));

  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    open_set |-> (pre_cnt >= PRE_SAT));

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int N_RP    = 3,
  parameter int N_RCD   = 3,
  parameter int N_CASLO = 3,
  parameter int N_CPX   = 1,
  localparam int TMAX   = imax(imax(N_RP, N_RCD), imax(N_CASLO, N_CPX)),
  localparam int TW     = $clog2(TMAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic q_we,
  input  logic row_open,
  input  logic row_hit,
  input  logic near_limit,
  input  logic ref_req,
  output logic req_ready,
  output logic accept,
  output logic ras_low,
  output logic cas_phase,
  output logic addr_col,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic cap_stb,
  output logic ref_gnt,
  output logic open_set,
  output logic open_clr
);

  edo_st_e       st, nxt;
  logic [TW-1:0] tmr, nxt_tmr;
  logic          pend;
  logic          tmr_done;

  assign tmr_done = (tmr == '0);

  always_comb begin
    nxt     = st;
    nxt_tmr = tmr_done ? '0 : tmr - 1'b1;
    case (st)
      ST_IDLE: begin
        if (ref_req) begin
          if (row_open) begin nxt = ST_PRE; nxt_tmr = TW'(N_RP - 1); end
          else                nxt = ST_GNT;
        end else if (row_open && near_limit) begin
          nxt = ST_PRE; nxt_tmr = TW'(N_RP - 1);
        end else if (req_valid) begin
          if (!row_open)    nxt = ST_ACT;
          else if (row_hit) nxt = ST_COL;
          else begin nxt = ST_PRE; nxt_tmr = TW'(N_RP - 1); end
        end
      end
      ST_PRE: if (tmr_done) begin
        if (pend)         nxt = ST_ACT;
        else if (ref_req) nxt = ST_GNT;
        else              nxt = ST_IDLE;
      end
      ST_ACT:  begin nxt = ST_RCD; nxt_tmr = TW'(N_RCD - 1); end
      ST_RCD:  if (tmr_done) nxt = ST_COL;
      ST_COL:  begin nxt = ST_CAS; nxt_tmr = TW'(N_CASLO - 1); end
      ST_CAS:  if (tmr_done) begin nxt = ST_CP; nxt_tmr = TW'(N_CPX - 1); end
      ST_CP:   if (tmr_done) nxt = ST_IDLE;
      ST_GNT:  if (!ref_req) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      tmr <= '0;
    end else begin
      st  <= nxt;
      tmr <= nxt_tmr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               pend <= 1'b0;
    else if (accept)                          pend <= 1'b1;
    else if (st == ST_CP && tmr_done)         pend <= 1'b0;
  end

  assign req_ready = (st == ST_IDLE) && !ref_req && !(row_open && near_limit);
  assign accept    = req_ready && req_valid;
  assign ras_low   = (st == ST_RCD) || (st == ST_COL) || (st == ST_CAS) ||
                     (st == ST_CP)  || ((st == ST_IDLE) && row_open);
  assign cas_phase = (st == ST_CAS);
  assign addr_col  = (st == ST_COL) || (st == ST_CAS);
  assign dq_oe     = q_we && addr_col;
  assign we_n      = !dq_oe;
  assign oe_n      = !(!q_we && cas_phase);
  assign cap_stb   = cas_phase && tmr_done && !q_we;
  assign ref_gnt   = (st == ST_GNT);
  assign open_set  = (st == ST_ACT);
  assign open_clr  = (st == ST_IDLE) && (nxt == ST_PRE);

  p_we_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_phase) && q_we) |-> ($past(we_n) == 1'b0));

  p_gnt_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> !row_open);

endmodule

// File: rtl/edo_lane_io.sv
module edo_lane_io #(
  parameter int NL = 4,
  localparam int DW = NL * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cas_phase,
  input  logic          cap_stb,
  input  logic [NL-1:0] be,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_i,
  output logic [NL-1:0] cas_n,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata,
  output logic          rsp_valid
);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign cas_n[i]       = !(cas_phase && be[i]);
    assign dq_o[8*i +: 8] = wdata[8*i +: 8];

    always_ff @(posedge clk) begin
      if (!rst_n)       rdata[8*i +: 8] <= '0;
      else if (cap_stb) rdata[8*i +: 8] <= be[i] ? dq_i[8*i +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= cap_stb;
  end

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_NS      = 8,
  parameter int ROW_W       = 9,
  parameter int COL_W       = 9,
  parameter int NL          = 4,
  parameter int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int T_RP_NS     = 20,
  parameter int T_RCD_NS    = 20,
  parameter int T_CAS_NS    = 5,
  parameter int T_CAC_NS    = 9,
  parameter int T_CP_NS     = 5,
  parameter int T_PC_NS     = 12,
  parameter int T_RASMAX_NS = 100000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [NL*8-1:0]        req_wdata,
  input  logic [NL-1:0]          req_be,
  output logic                   rsp_valid,
  output logic [NL*8-1:0]        rsp_rdata,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic                   dram_ras_n,
  output logic [NL-1:0]          dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [MUX_W-1:0]       dram_addr,
  output logic [NL*8-1:0]        dram_dq_o,
  output logic                   dram_dq_oe,
  input  logic [NL*8-1:0]        dram_dq_i
);

  localparam int AW       = ROW_W + COL_W;
  localparam int DW       = NL * 8;
  localparam int N_RP     = ns2clk(T_RP_NS, CLK_NS);
  localparam int N_RCD    = ns2clk(T_RCD_NS, CLK_NS);
  localparam int N_CAC    = ns2clk(T_CAC_NS, CLK_NS);
  localparam int N_CASLO  = imax(N_CAC + 1, ns2clk(T_CAS_NS, CLK_NS));
  localparam int N_CPX    = imax(ns2clk(T_CP_NS, CLK_NS),
                                 ns2clk(T_PC_NS, CLK_NS) - N_CASLO - 1);
  localparam int N_RASMAX = T_RASMAX_NS / CLK_NS;
  localparam int GUARD    = page_guard(N_CASLO, N_CPX);
  localparam int RCW      = $clog2(N_RASMAX + 2);

  logic          q_we;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic [NL-1:0] q_be;

  logic accept, ras_low, cas_phase, addr_col, cap_stb, open_set, open_clr;
  logic row_open, row_hit, near_limit;
  logic [RCW-1:0] ras_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_we <= 1'b0; q_addr <= '0; q_wdata <= '0; q_be <= '0;
    end else if (accept) begin
      q_we <= req_we; q_addr <= req_addr; q_wdata <= req_wdata; q_be <= req_be;
    end
  end

  edo_seq #(
    .N_RP(N_RP), .N_RCD(N_RCD), .N_CASLO(N_CASLO), .N_CPX(N_CPX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .q_we(q_we),
    .row_open(row_open), .row_hit(row_hit), .near_limit(near_limit),
    .ref_req(ref_req), .req_ready(req_ready), .accept(accept),
    .ras_low(ras_low), .cas_phase(cas_phase), .addr_col(addr_col),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
    .cap_stb(cap_stb), .ref_gnt(ref_gnt), .open_set(open_set),
    .open_clr(open_clr)
  );

  edo_page_track #(
    .ROW_W(ROW_W), .N_RP(N_RP), .N_RASMAX(N_RASMAX), .GUARD(GUARD)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .open_set(open_set),
    .open_clr(open_clr), .row_in(q_addr[AW-1:COL_W]),
    .cmp_row(req_addr[AW-1:COL_W]), .row_open(row_open),
    .row_hit(row_hit), .near_limit(near_limit), .ras_cnt(ras_cnt)
  );

  edo_lane_io #(.NL(NL)) u_lanes (
    .clk(clk), .rst_n(rst_n), .cas_phase(cas_phase), .cap_stb(cap_stb),
    .be(q_be), .wdata(q_wdata), .dq_i(dram_dq_i), .cas_n(dram_cas_n),
    .dq_o(dram_dq_o), .rdata(rsp_rdata), .rsp_valid(rsp_valid)
  );

  assign dram_ras_n = !ras_low;
  assign dram_addr  = addr_col ? MUX_W'(q_addr[COL_W-1:0])
                               : MUX_W'(q_addr[AW-1:COL_W]);

  p_rcd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_phase) |-> (ras_cnt >= RCW'(N_RCD)));

  p_hit_no_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && row_hit) |=> !dram_ras_n);

endmodule

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb_top;

  localparam int CLK  = 8;
  localparam int RMAX_NS = 400;
  // clock counts restated: quotient plus one when a remainder is left
  localparam int E_RP  = 20 / CLK + ((20 % CLK) != 0 ? 1 : 0);
  localparam int E_RCD = 20 / CLK + ((20 % CLK) != 0 ? 1 : 0);
  localparam int E_CAC = 9 / CLK + ((9 % CLK) != 0 ? 1 : 0);
  localparam int E_CP  = 5 / CLK + ((5 % CLK) != 0 ? 1 : 0);
  localparam int E_RMX = RMAX_NS / CLK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic req_ready, rsp_valid, ref_gnt;
  logic [31:0] rsp_rdata;
  logic dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [3:0] dram_cas_n;
  logic [8:0] dram_addr;
  logic [31:0] dram_dq_o;
  logic [31:0] dram_dq_i = '0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  edo_dram_ctrl #(.CLK_NS(CLK), .T_RASMAX_NS(RMAX_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
    .dram_dq_i(dram_dq_i)
  );

  function automatic logic [31:0] seed(input int k);
    return 32'h3C00_0000 ^ (k * 32'h0001_0107);
  endfunction

  // ---------------- memory model ----------------
  logic [31:0] mem [int];
  logic [8:0] m_row = '0, m_col = '0;
  logic m_pras = 1'b1;
  logic [3:0] m_pcas = 4'hF;
  int m_cnt = 0;

  always @(posedge clk) begin
    int k;
    logic [31:0] w;
    if (!dram_ras_n && m_pras) m_row = dram_addr;
    for (int i = 0; i < 4; i++) begin
      if (!dram_cas_n[i] && m_pcas[i]) begin
        m_col = dram_addr;
        if (!dram_we_n) begin
          k = int'({m_row, dram_addr});
          w = mem.exists(k) ? mem[k] : seed(k);
          w[8*i +: 8] = dram_dq_oe ? dram_dq_o[8*i +: 8] : 8'hEE;
          mem[k] = w;
        end
      end
    end
    m_cnt = (dram_cas_n != 4'hF) ? m_cnt + 1 : 0;
    k = int'({m_row, m_col});
    dram_dq_i <= (m_cnt >= E_CAC && dram_we_n) ?
                 (mem.exists(k) ? mem[k] : seed(k)) : 32'hDEAD_BEEF;
    m_pras = dram_ras_n;
    m_pcas = dram_cas_n;
  end

  // ---------------- pin monitor ----------------
  logic p_ras = 1'b1, p_we = 1'b1;
  logic p_cas_hi = 1'b1;
  int hi_run = 0, lo_run = 0, cas_hi_run = 0;
  int ras_falls = 0, min_pre = 1000, max_lo = 0, min_rcd = 1000, min_cp = 1000;
  int we_viol = 0, oe_viol = 0;
  bit first_in_row = 1;

  always @(negedge clk) begin
    logic cas_hi;
    if (rst_n) begin
      cas_hi = (dram_cas_n == 4'hF);
      if (!dram_ras_n) begin
        if (p_ras) begin
          ras_falls++;
          if (hi_run < min_pre) min_pre = hi_run;
          lo_run = 1; first_in_row = 1; cas_hi_run = 0;
        end else lo_run++;
        if (lo_run > max_lo) max_lo = lo_run;
        hi_run = 0;
      end else begin
        hi_run++; lo_run = 0;
      end
      if (!cas_hi && p_cas_hi) begin
        if (first_in_row) begin
          if (lo_run - 1 < min_rcd) min_rcd = lo_run - 1;
        end else if (cas_hi_run < min_cp) min_cp = cas_hi_run;
        first_in_row = 0;
        if (!dram_we_n && p_we) we_viol++;
      end
      if (cas_hi) cas_hi_run++; else cas_hi_run = 0;
      if (!dram_oe_n && (dram_dq_oe || !dram_we_n)) oe_viol++;
      p_ras = dram_ras_n; p_cas_hi = cas_hi; p_we = dram_we_n;
    end
  end

  // ---------------- scoreboard and helpers ----------------
  logic [31:0] sb [int];

  function automatic logic [31:0] exp_word(input int k);
    return sb.exists(k) ? sb[k] : seed(k);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wait_ready();
    int t = 0;
    while (!req_ready && t < 500) begin @(negedge clk); t++; end
  endtask

  task automatic issue(input logic we, input logic [17:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    wait_ready();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [17:0] a, input logic [31:0] d,
                          input logic [3:0] be);
    logic [31:0] m;
    issue(1'b1, a, d, be);
    wait_ready();
    m = lane_mask(be);
    sb[int'(a)] = (exp_word(int'(a)) & ~m) | (d & m);
  endtask

  task automatic do_read(input string rq, input logic [17:0] a,
                         input logic [3:0] be);
    int t = 0;
    issue(1'b0, a, 32'h0, be);
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    chk(rq, rsp_rdata, exp_word(int'(a)) & lane_mask(be));
    @(negedge clk);
    chk({rq, " pulse"}, {31'b0, rsp_valid}, 32'h0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 ras", {31'b0, dram_ras_n}, 32'h1);
    chk("R1 cas", {28'b0, dram_cas_n}, 32'hF);
    chk("R1 we/oe/dq", {29'b0, dram_we_n, dram_oe_n, dram_dq_oe}, 32'h6);
    chk("R1 rsp/gnt/ready", {29'b0, rsp_valid, ref_gnt, req_ready}, 32'h1);
  endtask

  task automatic t_addr_split();
    do_write(18'h2A5C3, 32'h1234_5678, 4'hF);
    chk("R2 row latched", {23'b0, m_row}, {23'b0, 9'(18'h2A5C3 >> 9)});
    chk("R2 col latched", {23'b0, m_col}, {23'b0, 9'(18'h2A5C3)});
    do_read("R4 full read", 18'h2A5C3, 4'hF);
  endtask

  task automatic t_byte_lanes();
    do_write(18'h00105, 32'hA1B2_C3D4, 4'hF);
    do_write(18'h00105, 32'h5566_7788, 4'b0101);
    do_read("R3 masked write merge", 18'h00105, 4'hF);
    do_write(18'h00105, 32'hFFFF_FFFF, 4'b0000);
    do_read("R3 no-lane write ignored", 18'h00105, 4'hF);
    do_read("R4 single lane read", 18'h00105, 4'b0010);
  endtask

  task automatic t_page_hit();
    int f0;
    do_read("R5 open row", 18'h0C010, 4'hF);
    f0 = ras_falls;
    do_write(18'h0C011, 32'hCAFE_0001, 4'hF);
    do_read("R5 hit read a", 18'h0C011, 4'hF);
    do_read("R5 hit read b", 18'h0C1FF, 4'hF);
    chk("R5 no new row strobe", ras_falls - f0, 0);
  endtask

  task automatic t_row_miss();
    int f0;
    f0 = ras_falls;
    do_read("R6 miss read", 18'h3FE00, 4'hF);
    chk("R6 one row strobe", ras_falls - f0, 1);
    chk("R6 precharge clocks", (min_pre >= E_RP), 1);
  endtask

  task automatic t_timing();
    chk("R7 row to column", (min_rcd >= E_RCD), 1);
    chk("R7 column precharge", (min_cp >= E_CP), 1);
    chk("R3 write enable leads", we_viol, 0);
    chk("R3 output enable off in write", oe_viol, 0);
  endtask

  task automatic t_ras_limit();
    int f0;
    f0 = ras_falls;
    for (int i = 0; i < 20; i++) do_read("R8 stream", 18'h15000 + 18'(i), 4'hF);
    chk("R8 row reopened", (ras_falls - f0 >= 1), 1);
    repeat (E_RMX + 10) @(negedge clk);
    chk("R8 idle row closed", {31'b0, dram_ras_n}, 32'h1);
    chk("R8 max low clocks", (max_lo <= E_RMX), 1);
  endtask

  task automatic t_refresh();
    int t = 0;
    do_read("R9 open before", 18'h07007, 4'hF);
    @(negedge clk); ref_req = 1'b1;
    while (!ref_gnt && t < 50) begin @(negedge clk); t++; end
    chk("R9 grant", {31'b0, ref_gnt}, 32'h1);
    chk("R9 strobes high", {27'b0, dram_ras_n, dram_cas_n}, 32'h1F);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 18'h07007; req_be = 4'hF;
    repeat (4) @(negedge clk);
    chk("R9 not ready", {30'b0, req_ready, ref_gnt}, 32'h1);
    chk("R9 pending not started", {31'b0, dram_ras_n}, 32'h1);
    req_valid = 1'b0;
    ref_req = 1'b0;
    @(negedge clk);
    chk("R9 released", {31'b0, ref_gnt}, 32'h0);
    do_read("R9 read after grant", 18'h07007, 4'hF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_split();
    t_byte_lanes();
    t_page_hit();
    t_row_miss();
    t_timing();
    t_ras_limit();
    t_refresh();
    t_timing();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

endmodule